// File: doc/BRIEF.md
# AAL5 Multi-Circuit Reassembly Engine

This block rebuilds AAL5 frames from a stream of ATM cell payloads. Cells of many virtual circuits may be interleaved on the input, but the beats of a single cell are never mixed with those of another. Each cell arrives as twelve 32-bit beats. Every circuit with a frame in progress is bound to one entry of a small shared pool of reassembly contexts. A context holds only an in-progress bit, a CRC-32 residual and the pointer record of its packet: head, tail and cell count.

Each accepted cell takes a buffer pointer from an internal free list. The cell's payload is written out to an external cell store at that pointer, and the cell is linked behind the previous tail of its frame. When the final cell of a frame has been taken in, the engine checks the CRC and the trailer length. It then emits a one-cycle descriptor that gives the head pointer, the cell count and a status code. The consumer walks the chain and hands each pointer back through the return port.

If a frame starts while every context is busy, that circuit is discarded up to and including its next final cell, and a discard descriptor is issued.

Top module: `aal5_reasm`

## Requirements
- R1: A cell is 12 beats, and a beat transfers on a cycle where `cell_valid` and `cell_ready` are both high. Beat bytes are big-endian, with the first byte in bits 31:24. `cell_vc` and `cell_eof` are sampled on the first beat only. `cell_ready` is low only on a first beat while the free list is empty.
- R2: The first cell of a circuit that holds no context takes the lowest-numbered idle context. Later cells of that circuit use the same context, and the context is released when the final cell is accepted. Up to NUM_CTX frames are reassembled at once.
- R3: Every accepted beat of a non-discarded cell drives `buf_wr_en` with `buf_wr_addr` = {pointer, beat index}. The pointer is popped from the free list on the first beat. After reset the free list yields 0, 1, 2, … in order.
- R4: When a cell is appended to a frame that already holds cells, a link write is issued from the old tail pointer to the new pointer. The first cell of a frame issues no link write.
- R5: One cycle after the last beat of a final cell is accepted, `desc_valid` pulses for one cycle. It carries the circuit, the head pointer and the number of cells.
- R6: The CRC-32 uses polynomial 0x04C11DB7 with an all-ones preset and shifts message bits in MSB first. It covers every byte of the frame, trailer included. A residual of 0xC704DD7B with a consistent length gives status 0 (good).
- R7: A residual other than 0xC704DD7B gives status 1. The full chain is still reported.
- R8: The length field is bits 15:0 of beat 10 of the final cell. When ceil((length+8)/48) differs from the cell count and the CRC is correct, the status is 2. A CRC error takes precedence over a length error.
- R9: A frame that starts with no idle context is discarded through its final cell. Its cells cause no buffer writes and take no pointers. A descriptor with status 3, head 0 and cell count 0 is issued for it.
- R10: A pointer given with `ret_valid` is appended to the tail of the free list and is handed out again in FIFO order.
- R11: After reset `cell_ready` is high and no descriptor, buffer write or link write is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_valid | input | 1 | Payload beat present |
| cell_ready | output | 1 | Engine takes the beat |
| cell_vc | input | VC_W | Circuit index, read on the first beat |
| cell_eof | input | 1 | Final cell of frame, read on the first beat |
| cell_data | input | 32 | Payload beat |
| buf_wr_en | output | 1 | Cell store write strobe |
| buf_wr_addr | output | PTR_W+4 | {pointer, beat index} |
| buf_wr_data | output | 32 | Cell store write data |
| lnk_wr_en | output | 1 | Link write strobe |
| lnk_wr_ptr | output | PTR_W | Cell whose link is written |
| lnk_wr_next | output | PTR_W | Next cell in the chain |
| desc_valid | output | 1 | Descriptor strobe |
| desc_vc | output | VC_W | Circuit of the frame |
| desc_head | output | PTR_W | First cell pointer |
| desc_cells | output | CNT_W | Cells in the chain |
| desc_status | output | 2 | 0 good, 1 CRC error, 2 length error, 3 discarded |
| ret_valid | input | 1 | Pointer return strobe |
| ret_ptr | input | PTR_W | Pointer being freed |

## Verification
The bench builds the engine with its default parameters: 64 circuits, 8 contexts and 256 buffers. With 8 contexts, a group of nine frames started together runs the pool dry, so the discard path and its persistence up to the final cell are reached. With 256 buffers, a single 256-cell frame empties the free list, which exposes the first-beat stall, the reuse of a returned pointer and a cell count that needs all 9 bits. Interleaved groups mix good, CRC-corrupted and length-corrupted frames. A second round reuses circuits from the first round to show that contexts are released.

// File: rtl/aal5_reasm.sv
module aal5_reasm #(
  parameter int NUM_VC  = 64,
  parameter int NUM_CTX = 8,
  parameter int NUM_BUF = 256,
  localparam int VC_W  = $clog2(NUM_VC),
  localparam int CX_W  = $clog2(NUM_CTX),
  localparam int PTR_W = $clog2(NUM_BUF),
  localparam int CNT_W = $clog2(NUM_BUF + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cell_valid,
  output logic             cell_ready,
  input  logic [VC_W-1:0]  cell_vc,
  input  logic             cell_eof,
  input  logic [31:0]      cell_data,
  output logic             buf_wr_en,
  output logic [PTR_W+3:0] buf_wr_addr,
  output logic [31:0]      buf_wr_data,
  output logic             lnk_wr_en,
  output logic [PTR_W-1:0] lnk_wr_ptr,
  output logic [PTR_W-1:0] lnk_wr_next,
  output logic             desc_valid,
  output logic [VC_W-1:0]  desc_vc,
  output logic [PTR_W-1:0] desc_head,
  output logic [CNT_W-1:0] desc_cells,
  output logic [1:0]       desc_status,
  input  logic             ret_valid,
  input  logic [PTR_W-1:0] ret_ptr
);
  localparam int BEATS = 12;
  localparam logic [31:0] POLY = 32'h04C11DB7;
  localparam logic [31:0] GOOD = 32'hC704DD7B;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) r = {r[30:0], 1'b0} ^ ({32{r[31] ^ d[i]}} & POLY);
    return r;
  endfunction

  logic [3:0]        beat;
  logic              cur_drop, cur_eof;
  logic [CX_W-1:0]   cur_ctx;
  logic [VC_W-1:0]   cur_vc;
  logic [PTR_W-1:0]  cur_ptr;
  logic [31:0]       cur_crc;
  logic [15:0]       cur_len;

  logic [NUM_VC-1:0] vc_has, vc_drop;
  logic [CX_W-1:0]   vc_ctx [NUM_VC];
  logic [NUM_CTX-1:0] cx_busy;
  logic [31:0]       cx_crc  [NUM_CTX];
  logic [PTR_W-1:0]  cx_head [NUM_CTX];
  logic [PTR_W-1:0]  cx_tail [NUM_CTX];
  logic [CNT_W-1:0]  cx_cnt  [NUM_CTX];

  logic [PTR_W-1:0]  fl [NUM_BUF];
  logic [PTR_W-1:0]  fl_rd, fl_wr;
  logic [CNT_W-1:0]  fl_cnt;

  logic            fr_ok;
  logic [CX_W-1:0] fr_idx;
  always_comb begin
    fr_ok  = 1'b0;
    fr_idx = '0;
    for (int i = NUM_CTX - 1; i >= 0; i--)
      if (!cx_busy[i]) begin
        fr_ok  = 1'b1;
        fr_idx = CX_W'(i);
      end
  end

  wire             first  = (beat == 4'd0);
  wire             last   = (beat == 4'(BEATS - 1));
  wire             acc    = cell_valid && cell_ready;
  wire             hit    = vc_has[cell_vc];
  wire             s_drop = !hit && (vc_drop[cell_vc] || !fr_ok);
  wire [CX_W-1:0]  s_ctx  = hit ? vc_ctx[cell_vc] : fr_idx;
  wire [PTR_W-1:0] fl_top = fl[fl_rd];
  wire             e_drop = first ? s_drop : cur_drop;
  wire [PTR_W-1:0] e_ptr  = first ? fl_top : cur_ptr;
  wire [31:0]      crc_in = first ? (hit ? cx_crc[s_ctx] : '1) : cur_crc;
  wire [31:0]      crc_nx = crc_step(crc_in, cell_data);
  wire [16:0]      need   = (17'(cur_len) + 17'd55) / 17'd48;
  wire             pop    = acc && first && !s_drop;

  assign cell_ready  = !first || (fl_cnt != '0);
  assign buf_wr_en   = acc && !e_drop;
  assign buf_wr_addr = {e_ptr, beat};
  assign buf_wr_data = cell_data;
  assign lnk_wr_en   = acc && first && hit;
  assign lnk_wr_ptr  = cx_tail[s_ctx];
  assign lnk_wr_next = fl_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat <= '0;
      cur_drop <= 1'b0; cur_eof <= 1'b0; cur_ctx <= '0; cur_vc <= '0;
      cur_ptr <= '0; cur_crc <= '0; cur_len <= '0;
      vc_has <= '0; vc_drop <= '0; cx_busy <= '0;
      for (int v = 0; v < NUM_VC; v++) vc_ctx[v] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        cx_crc[c] <= '0; cx_head[c] <= '0; cx_tail[c] <= '0; cx_cnt[c] <= '0;
      end
      for (int b = 0; b < NUM_BUF; b++) fl[b] <= PTR_W'(b);
      fl_rd <= '0; fl_wr <= '0; fl_cnt <= CNT_W'(NUM_BUF);
      desc_valid <= 1'b0; desc_vc <= '0; desc_head <= '0; desc_cells <= '0; desc_status <= '0;
    end else begin
      desc_valid <= 1'b0;
      if (ret_valid) begin
        fl[fl_wr] <= ret_ptr;
        fl_wr <= fl_wr + 1'b1;
      end
      fl_cnt <= fl_cnt + CNT_W'(ret_valid) - CNT_W'(pop);
      if (acc) begin
        beat    <= last ? 4'd0 : beat + 4'd1;
        cur_crc <= crc_nx;
        if (beat == 4'(BEATS - 2)) cur_len <= cell_data[15:0];
        if (first) begin
          cur_drop <= s_drop; cur_ctx <= s_ctx; cur_vc <= cell_vc;
          cur_eof <= cell_eof; cur_ptr <= fl_top;
          if (s_drop) vc_drop[cell_vc] <= 1'b1;
          else begin
            fl_rd <= fl_rd + 1'b1;
            cx_tail[s_ctx] <= fl_top;
            if (hit) cx_cnt[s_ctx] <= cx_cnt[s_ctx] + 1'b1;
            else begin
              vc_has[cell_vc] <= 1'b1;
              vc_ctx[cell_vc] <= s_ctx;
              cx_busy[s_ctx]  <= 1'b1;
              cx_head[s_ctx]  <= fl_top;
              cx_cnt[s_ctx]   <= CNT_W'(1);
            end
          end
        end
        if (last) begin
          if (!cur_drop) cx_crc[cur_ctx] <= crc_nx;
          if (cur_eof) begin
            desc_valid <= 1'b1;
            desc_vc    <= cur_vc;
            if (cur_drop) begin
              vc_drop[cur_vc] <= 1'b0;
              desc_head   <= '0;
              desc_cells  <= '0;
              desc_status <= 2'd3;
            end else begin
              vc_has[cur_vc]   <= 1'b0;
              cx_busy[cur_ctx] <= 1'b0;
              desc_head  <= cx_head[cur_ctx];
              desc_cells <= cx_cnt[cur_ctx];
              if (crc_nx != GOOD) desc_status <= 2'd1;
              else if (need != 17'(cx_cnt[cur_ctx])) desc_status <= 2'd2;
              else desc_status <= 2'd0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/aal5_reasm_chk.sv
module aal5_reasm_chk #(
  parameter int NUM_VC  = 64,
  parameter int NUM_CTX = 8,
  parameter int NUM_BUF = 256,
  localparam int PTR_W = $clog2(NUM_BUF),
  localparam int CNT_W = $clog2(NUM_BUF + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cell_valid,
  input logic               cell_ready,
  input logic               buf_wr_en,
  input logic               desc_valid,
  input logic [1:0]         desc_status,
  input logic [CNT_W-1:0]   desc_cells,
  input logic [PTR_W-1:0]   desc_head,
  input logic [NUM_VC-1:0]  vc_has,
  input logic [NUM_CTX-1:0] cx_busy,
  input logic [CNT_W-1:0]   fl_cnt
);
  AST_DESC_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> $past(cell_valid && cell_ready)); // R5
  AST_DESC_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_status != 2'd3 |-> desc_cells != '0); // R5
  AST_DISCARD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && desc_status == 2'd3 |-> desc_cells == '0 && desc_head == '0); // R9
  AST_CTX_VC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vc_has) == $countones(cx_busy)); // R2
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cnt <= CNT_W'(NUM_BUF)); // R10
  AST_WR_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> cell_valid && cell_ready); // R3
endmodule

bind aal5_reasm aal5_reasm_chk #(.NUM_VC(NUM_VC), .NUM_CTX(NUM_CTX), .NUM_BUF(NUM_BUF)) u_chk (
  .clk(clk), .rst_n(rst_n), .cell_valid(cell_valid), .cell_ready(cell_ready),
  .buf_wr_en(buf_wr_en), .desc_valid(desc_valid), .desc_status(desc_status),
  .desc_cells(desc_cells), .desc_head(desc_head), .vc_has(vc_has),
  .cx_busy(cx_busy), .fl_cnt(fl_cnt));

// File: tb/tb_aal5_reasm.sv
module tb_aal5_reasm;
  localparam int NCTX = 8;
  logic clk = 0, rst_n = 0;
  logic cell_valid = 0, cell_eof = 0, ret_valid = 0;
  logic [5:0] cell_vc = 0;
  logic [31:0] cell_data = 0;
  logic [7:0] ret_ptr = 0;
  logic cell_ready, buf_wr_en, lnk_wr_en, desc_valid;
  logic [11:0] buf_wr_addr;
  logic [31:0] buf_wr_data;
  logic [7:0] lnk_wr_ptr, lnk_wr_next, desc_head;
  logic [5:0] desc_vc;
  logic [8:0] desc_cells;
  logic [1:0] desc_status;

  aal5_reasm dut (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, nwr = 0, ndesc = 0, nlnk = 0;
  logic [31:0] bmem [4096];
  logic [7:0] lnk [256];
  logic [11:0] last_addr;
  int d_vc [128], d_head [128], d_cells [128], d_st [128], d_cyc [128];
  int fq [$];
  int active = 0;

  // vc, cells, kind (0 good, 1 CRC corrupt, 2 length corrupt)
  localparam int VEC [17][3] = '{
    '{3, 3, 0}, '{10, 1, 0}, '{17, 4, 1}, '{40, 2, 2}, '{63, 5, 0},
    '{1, 2, 0}, '{2, 2, 0}, '{4, 2, 0}, '{5, 2, 0}, '{6, 2, 1},
    '{7, 2, 0}, '{8, 2, 0}, '{9, 2, 0}, '{11, 2, 0},
    '{3, 1, 1}, '{10, 2, 0}, '{0, 6, 2}};
  localparam int GRP [3][2] = '{'{0, 5}, '{5, 9}, '{14, 3}};

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (buf_wr_en) begin bmem[buf_wr_addr] = buf_wr_data; last_addr = buf_wr_addr; nwr++; end
    if (lnk_wr_en) begin lnk[lnk_wr_ptr] = lnk_wr_next; nlnk++; end
    if (desc_valid) begin
      d_vc[ndesc] = desc_vc; d_head[ndesc] = desc_head; d_cells[ndesc] = desc_cells;
      d_st[ndesc] = desc_status; d_cyc[ndesc] = cyc; ndesc++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 31; i >= 0; i--) r = r[31] ^ d[i] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    return r;
  endfunction

  function automatic logic [31:0] pay(input int vc, input int c, input int b);
    return {8'(vc), 8'(c), 8'(8'hA0 + b), ~8'(vc)};
  endfunction

  task automatic send_cell(input int vc, input bit eof, input logic [31:0] w [12], output int ts);
    for (int b = 0; b < 12; b++) begin
      cell_valid = 1; cell_vc = 6'(vc); cell_eof = eof; cell_data = w[b];
      @(negedge clk);
      while (!cell_ready) begin @(posedge clk); #1; @(negedge clk); end
      ts = cyc;
      @(posedge clk); #1;
    end
    cell_valid = 0;
  endtask

  task automatic ret(input int p);
    ret_valid = 1; ret_ptr = 8'(p);
    @(posedge clk); #1;
    ret_valid = 0;
  endtask

  function automatic void build(input int vc, input int c, input bit eof, input int len,
                                input bit bad, inout logic [31:0] crc, output logic [31:0] w [12]);
    for (int b = 0; b < 12; b++) begin
      if (eof && b == 10) w[b] = {16'h0, 16'(len)};
      else if (eof && b == 11) w[b] = ~crc ^ {31'h0, bad};
      else w[b] = pay(vc, c, b);
      if (!(eof && b == 11)) crc = crc_upd(crc, w[b]);
    end
  endfunction

  task automatic run_group(input int s, input int n);
    int left [16], sent [16], hd [16], ts [16];
    bit drp [16];
    logic [31:0] crc [16];
    logic [31:0] w [12];
    int nd0, wr0, expwr;
    bit any;
    nd0 = ndesc; wr0 = nwr; expwr = 0;
    for (int i = 0; i < n; i++) begin
      left[i] = VEC[s+i][1]; sent[i] = 0; crc[i] = '1; drp[i] = 0; hd[i] = 0;
    end
    any = 1;
    while (any) begin
      any = 0;
      for (int i = 0; i < n; i++) if (left[i] > 0) begin
        int vc, nc, kind, len;
        bit eof;
        any = 1;
        vc = VEC[s+i][0]; nc = VEC[s+i][1]; kind = VEC[s+i][2];
        eof = (left[i] == 1);
        len = (kind == 2) ? 48 * nc : 48 * nc - 13;
        if (sent[i] == 0) begin
          if (active < NCTX) begin active++; hd[i] = fq.pop_front(); end
          else drp[i] = 1;
        end else if (!drp[i]) void'(fq.pop_front());
        build(vc, sent[i], eof, len, kind == 1, crc[i], w);
        send_cell(vc, eof, w, ts[i]);
        if (!drp[i]) expwr += 12;
        sent[i]++; left[i]--;
        if (left[i] == 0 && !drp[i]) active--;
      end
    end
    repeat (3) @(posedge clk); #1;
    chk(ndesc - nd0 == n, "R5 descriptor count", ndesc - nd0, n);
    chk(nwr - wr0 == expwr, "R9 buffer write count", nwr - wr0, expwr);
    for (int d = nd0; d < ndesc; d++) begin
      int i, est, ecells;
      i = -1;
      for (int k = 0; k < n; k++) if (VEC[s+k][0] == d_vc[d]) i = k;
      chk(i >= 0, "R5 descriptor circuit", d_vc[d], -1);
      if (i >= 0) begin
        est = drp[i] ? 3 : VEC[s+i][2];
        ecells = drp[i] ? 0 : VEC[s+i][1];
        chk(d_st[d] == est, est == 3 ? "R9 status" : est == 1 ? "R7 status" : est == 2 ? "R8 status" : "R6 status", d_st[d], est);
        chk(d_cells[d] == ecells, "R5 cells", d_cells[d], ecells);
        chk(d_head[d] == hd[i], "R3 head pointer", d_head[d], hd[i]);
        chk(d_cyc[d] == ts[i] + 1, "R5 descriptor timing", d_cyc[d], ts[i] + 1);
        if (est != 3) begin
          int p, bad;
          p = d_head[d]; bad = 0;
          for (int c = 0; c < ecells; c++) begin
            int nx;
            if (bmem[{p[7:0], 4'd0}] != pay(d_vc[d], c, 0)) bad++;
            nx = lnk[p];
            ret(p); fq.push_back(p);
            p = nx;
          end
          chk(bad == 0, "R4 chain contents", bad, 0);
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w [12];
    logic [31:0] crc;
    int ts, nd0;
    for (int i = 0; i < 256; i++) fq.push_back(i);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(cell_ready == 1, "R11 ready after reset", cell_ready, 1);
    chk(desc_valid == 0 && buf_wr_en == 0 && lnk_wr_en == 0, "R11 idle outputs", desc_valid, 0);
    @(posedge clk); #1;

    for (int g = 0; g < 3; g++) run_group(GRP[g][0], GRP[g][1]);

    // R1 / R10: drain the free list with one long frame, stall, return a pointer, finish
    crc = '1;
    for (int c = 0; c < 256; c++) begin
      build(20, c, 0, 0, 0, crc, w);
      send_cell(20, 0, w, ts);
    end
    cell_valid = 1; cell_vc = 6'd20; cell_eof = 1; cell_data = 0;
    @(negedge clk);
    chk(cell_ready == 0, "R1 stall on empty free list", cell_ready, 0);
    @(posedge clk); #1;
    cell_valid = 0;
    ret(8'hA5);
    nd0 = ndesc;
    build(20, 256, 1, 257 * 48 - 13, 0, crc, w);
    send_cell(20, 1, w, ts);
    repeat (3) @(posedge clk); #1;
    chk(last_addr[11:4] == 8'hA5, "R10 returned pointer reused", last_addr[11:4], 8'hA5);
    chk(ndesc == nd0 + 1, "R5 long frame descriptor", ndesc - nd0, 1);
    chk(d_cells[nd0] == 257, "R5 long frame cells", d_cells[nd0], 257);
    chk(d_st[nd0] == 0, "R6 long frame status", d_st[nd0], 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule